// File: doc/BRIEF.md
# Six-Input Logic Element with Split Cofactor Tables

This block is a configurable logic element for a programmable fabric. It takes six data inputs and one output. A 32-entry table addressed by the five low inputs holds one cofactor of the target function. A 16-entry table addressed by the four low inputs holds the other cofactor. The sixth input, compared against a stored polarity bit, chooses which table drives the output. The element therefore realises every function of five or fewer inputs. It also realises every six-input function whose cofactor with respect to the sixth input needs no more than four variables, and it does so with 49 storage cells in place of 64.

All 49 cells sit on one serial scan chain. While the shift enable is high, one bit enters per clock and the oldest bit leaves on the scan output, so a new load reads back the previous contents. While loading, the element drives a constant low output so that a partly written configuration never reaches downstream logic. Input bit 0 is i1 and bit 5 is i6 (the decomposition input).

Top module: `trim_lut_elem`

## Requirements
- R1: After reset every cell holds 0: with `cfg_en` low the output is 0 for any input, and `cfg_out` is 0.
- R2: While `cfg_en` is high, each clock shifts `cfg_in` into the chain. After 49 shifts, the first bit written is wide-table entry 0. The next bits are wide entries 1 to 31, then narrow-table entries 0 to 15, and the last bit written is the polarity bit.
- R3: `cfg_out` shows the oldest stored bit. During a load, shift k (counted from 0) presents the previous configuration's bit k, in the same order as R2.
- R4: While `cfg_en` is low, the configuration does not change, whatever `cfg_in` does.
- R5: With `cfg_en` low and i6 equal to the polarity bit, `lut_out` is wide-table entry `x_in[4:0]` (i1 is the least significant address bit). Fixing i6 in this way realises any five-input function.
- R6: With `cfg_en` low and i6 different from the polarity bit, `lut_out` is narrow-table entry `x_in[3:0]`, and i5 has no effect.
- R7: Inverting the polarity bit swaps which value of i6 routes the narrow table to the output.
- R8: While `cfg_en` is high, `lut_out` is 0.
- R9: Any six-input function whose 0- or 1-cofactor in i6 depends only on i1..i4 is realised exactly over all 64 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Oldest chain bit, used for readback |
| x_in | input | 6 | Data inputs; bit 0 = i1, bit 5 = i6 |
| lut_out | output | 1 | Element output |

## Verification
A table pair with parity in the wide table and a mod-3 pattern in the narrow one is swept over all 64 inputs under both polarities. This separates the two table paths, exposes any address-bit swap and shows whether the polarity inverts the choice. Two trimmed six-input functions are then checked exhaustively against their own formulas: one with a small 1-cofactor and one with a small 0-cofactor. Each load also checks the bits that come out of the previous load, which confirms both the shift order and the readback order. Idle cycles with a toggling `cfg_in` show that the stored state stays put.

// File: rtl/trim_lut_pkg.sv
package trim_lut_pkg;

  function automatic int unsigned table_cells(input int unsigned k);
    return 32'd1 << k;
  endfunction

  function automatic int unsigned chain_len(input int unsigned wide_k,
                                            input int unsigned narrow_k);
    return table_cells(wide_k) + table_cells(narrow_k) + 1;
  endfunction

  function automatic int unsigned tree_muxes(input int unsigned k);
    return table_cells(k) - 1;
  endfunction

endpackage

// File: rtl/tle_cfg_chain.sv
module tle_cfg_chain #(
  parameter int unsigned LEN = 49
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic [LEN-1:0] cells,
  output logic           ser_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (shift_en) begin
      cells <= {ser_in, cells[LEN-1:1]};
    end
  end

  assign ser_out = cells[0];
endmodule

// File: rtl/tle_mux_tree.sv
module tle_mux_tree #(
  parameter int unsigned K = 5,
  localparam int unsigned N = 1 << K
) (
  input  logic [N-1:0] cells,
  input  logic [K-1:0] sel,
  output logic         y
);
  for (genvar e = 0; e <= K; e++) begin : lvl_g
    localparam int unsigned W = 1 << (K - e);
    logic [W-1:0] v;
    if (e == 0) begin : g_leaf
      assign v = cells;
    end else begin : g_node
      for (genvar m = 0; m < W; m++) begin : g_mux
        assign v[m] = sel[e-1] ? lvl_g[e-1].v[2*m+1] : lvl_g[e-1].v[2*m];
      end
    end
  end

  assign y = lvl_g[K].v[0];
endmodule

// File: rtl/tle_out_sel.sv
module tle_out_sel (
  input  logic dec,
  input  logic pol,
  input  logic wide_res,
  input  logic narrow_res,
  output logic pol_hit,
  output logic y
);
  assign pol_hit = pol ? ~dec : dec;
  assign y       = pol_hit ? narrow_res : wide_res;
endmodule

// File: rtl/trim_lut_elem.sv
module trim_lut_elem
  import trim_lut_pkg::*;
#(
  parameter int unsigned WIDE_K   = 5,
  parameter int unsigned NARROW_K = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_in,
  output logic          cfg_out,
  input  logic [WIDE_K:0] x_in,
  output logic          lut_out
);
  localparam int unsigned WIDE_N   = table_cells(WIDE_K);
  localparam int unsigned NARROW_N = table_cells(NARROW_K);
  localparam int unsigned CFG_LEN  = chain_len(WIDE_K, NARROW_K);

  logic [CFG_LEN-1:0] cells;
  logic               wide_res;
  logic               narrow_res;
  logic               pol_hit;
  logic               y_raw;

  tle_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .cells    (cells),
    .ser_out  (cfg_out)
  );

  tle_mux_tree #(.K(WIDE_K)) u_wide (
    .cells (cells[WIDE_N-1:0]),
    .sel   (x_in[WIDE_K-1:0]),
    .y     (wide_res)
  );

  tle_mux_tree #(.K(NARROW_K)) u_narrow (
    .cells (cells[WIDE_N+NARROW_N-1:WIDE_N]),
    .sel   (x_in[NARROW_K-1:0]),
    .y     (narrow_res)
  );

  tle_out_sel u_sel (
    .dec        (x_in[WIDE_K]),
    .pol        (cells[CFG_LEN-1]),
    .wide_res   (wide_res),
    .narrow_res (narrow_res),
    .pol_hit    (pol_hit),
    .y          (y_raw)
  );

  assign lut_out = cfg_en ? 1'b0 : y_raw;
endmodule

// File: rtl/trim_lut_elem_chk.sv
module trim_lut_elem_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_out,
  input logic lut_out,
  input logic wide_res,
  input logic narrow_res,
  input logic pol_hit
);
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_out))
    else $error("p_cfg_hold_r4");

  p_quiet_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !lut_out)
    else $error("p_quiet_cfg_r8");

  p_wide_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !pol_hit) |-> (lut_out == wide_res))
    else $error("p_wide_path_r5");

  p_narrow_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && pol_hit) |-> (lut_out == narrow_res))
    else $error("p_narrow_path_r6");
endmodule

bind trim_lut_elem trim_lut_elem_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_out    (cfg_out),
  .lut_out    (lut_out),
  .wide_res   (wide_res),
  .narrow_res (narrow_res),
  .pol_hit    (pol_hit)
);

// File: tb/trim_lut_elem_tb_top.sv
module trim_lut_elem_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_in = 1'b0;
  logic [5:0] x_in = '0;
  wire        lut_out;
  wire        cfg_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_lut_elem dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_in  (cfg_in),
    .cfg_out (cfg_out),
    .x_in    (x_in),
    .lut_out (lut_out)
  );

  typedef struct {
    bit         chk_out;
    bit         exp_out;
    bit         chk_cfg;
    bit         exp_cfg;
    string      req;
    logic [5:0] stim;
  } item_t;

  item_t sb[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    m5[32];
  bit    m4[16];
  bit    ms;
  bit    p5[32];
  bit    p4[16];
  bit    ps;

  // monitor: sample at the falling edge, away from the shifting edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.chk_out) begin
        n_tests++;
        if (lut_out !== it.exp_out) begin
          n_fail++;
          $display("FAIL %s lut_out x=%b got %b exp %b", it.req, it.stim, lut_out, it.exp_out);
        end
      end
      if (it.chk_cfg) begin
        n_tests++;
        if (cfg_out !== it.exp_cfg) begin
          n_fail++;
          $display("FAIL %s cfg_out got %b exp %b", it.req, cfg_out, it.exp_cfg);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // reference: narrow table when i6 differs from polarity, else wide table
  function automatic bit model(input logic [5:0] x);
    if (x[5] == ms) return m5[x[4:0]];
    return m4[x[3:0]];
  endfunction

  task automatic push(input bit co, input bit eo, input bit cc, input bit ec,
                      input string req, input logic [5:0] x);
    item_t it;
    it.chk_out = co; it.exp_out = eo; it.chk_cfg = cc; it.exp_cfg = ec;
    it.req = req; it.stim = x;
    sb.push_back(it);
  endtask

  task automatic eval(input logic [5:0] x, input string tag, input bit use_exp, input bit e);
    string r;
    step();
    cfg_en = 1'b0;
    cfg_in = 1'($urandom);
    x_in   = x;
    if (tag != "") r = tag;
    else r = (x[5] != ms) ? "R6" : "R5";
    push(1'b1, use_exp ? e : model(x), 1'b0, 1'b0, r, x);
  endtask

  // shifts the staged tables in; checks readback of the old ones (R3)
  task automatic load();
    for (int k = 0; k < 49; k++) begin
      bit nb, ob;
      nb = (k < 32) ? p5[k] : ((k < 48) ? p4[k-32] : ps);
      ob = (k < 32) ? m5[k] : ((k < 48) ? m4[k-32] : ms);
      step();
      cfg_en = 1'b1;
      cfg_in = nb;
      x_in   = 6'($urandom);
      push(1'b1, 1'b0, 1'b1, ob, "R8 R3", x_in);
    end
    for (int j = 0; j < 32; j++) m5[j] = p5[j];
    for (int j = 0; j < 16; j++) m4[j] = p4[j];
    ms = ps;
    step();
    cfg_en = 1'b0;
    push(1'b0, 1'b0, 1'b1, m5[0], "R2", x_in);
  endtask

  function automatic bit g_hi(input logic [5:0] x);
    if (x[5]) return (x[0] & x[1]) | (x[2] ^ x[3]);
    return ^x[4:0];
  endfunction

  function automatic bit g_lo(input logic [5:0] x);
    if (x[5]) return (x[0] & x[1]) | (x[1] & x[4]) | (x[0] & x[4]) ^ x[2];
    return (x[0] | x[3]) & ~x[2];
  endfunction

  initial begin
    for (int j = 0; j < 32; j++) m5[j] = 1'b0;
    for (int j = 0; j < 16; j++) m4[j] = 1'b0;
    ms = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: cleared state
    for (int i = 0; i < 8; i++) eval(6'(i * 9), "R1", 1'b1, 1'b0);
    step();
    push(1'b0, 1'b0, 1'b1, 1'b0, "R1", x_in);

    // table pair A, polarity 0 (R2 order via R5/R6)
    for (int j = 0; j < 32; j++) p5[j] = ^5'(j);
    for (int j = 0; j < 16; j++) p4[j] = (j % 3) == 0;
    ps = 1'b0;
    load();
    for (int i = 0; i < 64; i++) eval(6'(i), "", 1'b0, 1'b0);

    // R4: idle with toggling serial input
    for (int i = 0; i < 20; i++) begin
      step();
      cfg_en = 1'b0;
      cfg_in = 1'($urandom);
      push(1'b0, 1'b0, 1'b1, m5[0], "R4", x_in);
    end
    for (int i = 0; i < 64; i += 5) eval(6'(i), "R4", 1'b0, 1'b0);

    // R7: same tables, inverted polarity
    ps = 1'b1;
    load();
    for (int i = 0; i < 64; i++) eval(6'(i), "R7", 1'b0, 1'b0);

    // R9: small 1-cofactor, polarity 0
    for (int j = 0; j < 32; j++) p5[j] = g_hi({1'b0, 5'(j)});
    for (int j = 0; j < 16; j++) p4[j] = g_hi({2'b10, 4'(j)});
    ps = 1'b0;
    load();
    for (int i = 0; i < 64; i++) eval(6'(i), "R9", 1'b1, g_hi(6'(i)));

    // R9: small 0-cofactor, polarity 1
    for (int j = 0; j < 32; j++) p5[j] = g_lo({1'b1, 5'(j)});
    for (int j = 0; j < 16; j++) p4[j] = g_lo({2'b00, 4'(j)});
    ps = 1'b1;
    load();
    for (int i = 0; i < 64; i++) eval(6'(i), "R9", 1'b1, g_lo(6'(i)));

    // final load reads back the last configuration (R3)
    for (int j = 0; j < 32; j++) p5[j] = 1'b0;
    for (int j = 0; j < 16; j++) p4[j] = 1'b0;
    ps = 1'b0;
    load();

    wait (sb.size() == 0);
    step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule